// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block connects a synchronous host to an external asynchronous static RAM of 128K words by 16 bits whose control lines are all active low. The host offers one request at a time through a valid/ready handshake. Each request carries a write flag, a 17-bit word address, 16 bits of write data and a two-bit lane mask. Bit 0 of the mask selects the low byte (data bits 7:0) and bit 1 selects the high byte (bits 15:8). A read returns its data with a one-cycle valid pulse.

On the memory side the controller drives the address, chip select, write strobe, output strobe and one select per byte lane, all from registers. It drives the shared data bus through its own output-enable. Every phase of an access lasts a whole number of clock cycles. Each count comes from a nanosecond minimum and the clock period in picoseconds: the quotient is rounded up and is never less than one. The host may not issue a request until a power-up wait has passed after reset. After every read the controller leaves a gap before it drives the bus again, so the memory's output drivers have time to turn off.

Top module: `sram_ctl`

## Requirements
- R1: During reset and whenever `req_ready` is high, chip select, write strobe and output strobe are high and the controller does not drive the bus. After reset is released, `req_ready` stays low for the power-up wait and then rises.
- R2: A write holds chip select low and output strobe high for the whole access. The write strobe is low for at least the pulse-width minimum (7 cycles at defaults). Lane select n is low exactly when mask bit n is 1 (bit 0 is the low byte, bit 1 the high byte).
- R3: The write strobe goes high one cycle before chip select and the lane selects are released. Address and data are driven unchanged from acceptance until after that edge, so address setup (7 cycles) and data setup (5 cycles) are met. Chip select stays low for at least the write cycle time (9 cycles).
- R4: A read holds chip select and output strobe low with the write strobe high for the larger of the address, select and output-enable access times (9 cycles at defaults). The bus is sampled at the end of that window, and `rd_valid` then pulses for exactly one cycle.
- R5: Read lanes whose mask bit is 0 return zero in `rd_data`. A write leaves the bytes of lanes whose mask bit is 0 unchanged, and a write with mask 00 changes nothing.
- R6: After the output strobe rises, the controller does not drive the bus for at least the float time (4 cycles at defaults).
- R7: The controller never drives the bus while the output strobe is low.
- R8: `req_ready` falls in the cycle after acceptance and stays low until the access and its gap are complete. Requests presented while it is low have no effect.
- R9: Each count is ceil(ns*1000/CLK_PS) with a minimum of one. At the default 5000 ps clock this gives: a write busy for 9 cycles, `rd_valid` 9 cycles after acceptance, ready again 13 cycles after a read is accepted, and a power-up wait of 40000 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, treated as power-on |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 16 | Write data |
| req_bmask | input | 2 | Lane mask, bit 0 low byte, bit 1 high byte |
| rd_valid | output | 1 | One-cycle pulse, read data valid |
| rd_data | output | 16 | Read data, disabled lanes zero |
| mem_addr | output | 17 | Memory address |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output strobe, active low |
| mem_bsel_n | output | 2 | Lane selects, active low, bit 1 high byte |
| mem_dq_out | output | 16 | Data the controller drives onto the bus |
| mem_dq_oe | output | 1 | Controller bus driver enable |
| mem_dq_in | input | 16 | Data read from the bus |

## Verification
The bench has a memory model that returns garbage until the read window has lasted the full access time. A controller that samples one cycle early therefore returns wrong data, and the model flags any write pulse, setup time or cycle time that is one cycle short. Writes with every lane mask, followed by reads with every mask at addresses that include both ends of the range, catch swapped lanes and masked bytes that get written anyway. A write followed directly by a read of the same word catches a missing data hold. Read-then-write sequences check that the bus gap survives. A request held valid while the controller is busy would overwrite a second address if the handshake leaked. The exact power-up and busy lengths expose rounding that truncates instead of rounding up.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_PWRUP,
    ST_IDLE,
    ST_WSETUP,
    ST_WPULSE,
    ST_WHOLD,
    ST_READ,
    ST_TURN
  } ctl_state_t;

  // Whole cycles covering a nanosecond minimum, never fewer than one.
  function automatic int ns_to_cyc(input int ns, input int clk_ps);
    int c;
    c = (ns * 1000 + clk_ps - 1) / clk_ps;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
  parameter int W       = 16,
  parameter int RST_VAL = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= W'(RST_VAL);
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign done = (cnt == '0);

endmodule

// File: rtl/sram_ctl_lanes.sv
module sram_ctl_lanes #(
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input  logic [LANES-1:0]        mask,
  input  logic [LANES*LANE_W-1:0] raw,
  output logic [LANES*LANE_W-1:0] merged
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign merged[g*LANE_W +: LANE_W] = mask[g] ? raw[g*LANE_W +: LANE_W] : '0;
  end

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W      = 17,
  parameter int DATA_W      = 16,
  parameter int LANE_W      = 8,
  parameter int CLK_PS      = 5000,
  parameter int T_WC_NS     = 45,
  parameter int T_PWE_NS    = 35,
  parameter int T_AW_NS     = 35,
  parameter int T_SD_NS     = 25,
  parameter int T_SA_NS     = 0,
  parameter int T_HOLD_NS   = 0,
  parameter int T_RC_NS     = 45,
  parameter int T_AA_NS     = 45,
  parameter int T_ACE_NS    = 45,
  parameter int T_DOE_NS    = 22,
  parameter int T_HZ_NS     = 18,
  parameter int T_PWRUP_NS  = 200000
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic                       req_write,
  input  logic [ADDR_W-1:0]          req_addr,
  input  logic [DATA_W-1:0]          req_wdata,
  input  logic [DATA_W/LANE_W-1:0]   req_bmask,
  output logic                       rd_valid,
  output logic [DATA_W-1:0]          rd_data,
  output logic [ADDR_W-1:0]          mem_addr,
  output logic                       mem_ce_n,
  output logic                       mem_we_n,
  output logic                       mem_oe_n,
  output logic [DATA_W/LANE_W-1:0]   mem_bsel_n,
  output logic [DATA_W-1:0]          mem_dq_out,
  output logic                       mem_dq_oe,
  input  logic [DATA_W-1:0]          mem_dq_in
);

  localparam int LANES     = DATA_W / LANE_W;
  localparam int SETUP_CYC = ns_to_cyc(T_SA_NS, CLK_PS);
  localparam int HOLD_CYC  = ns_to_cyc(T_HOLD_NS, CLK_PS);
  localparam int PWE_CYC   = ns_to_cyc(T_PWE_NS, CLK_PS);
  localparam int AW_CYC    = ns_to_cyc(T_AW_NS, CLK_PS);
  localparam int SD_CYC    = ns_to_cyc(T_SD_NS, CLK_PS);
  localparam int WC_CYC    = ns_to_cyc(T_WC_NS, CLK_PS);
  // Strobe-low length: covers pulse width, address/data setup to the
  // rising strobe, and the full cycle time with setup and hold included.
  localparam int PULSE_CYC = imax(imax(PWE_CYC, AW_CYC - SETUP_CYC),
                                  imax(SD_CYC - SETUP_CYC, WC_CYC - SETUP_CYC - HOLD_CYC));
  localparam int READ_CYC  = imax(imax(ns_to_cyc(T_AA_NS, CLK_PS), ns_to_cyc(T_ACE_NS, CLK_PS)),
                                  imax(ns_to_cyc(T_DOE_NS, CLK_PS), ns_to_cyc(T_RC_NS, CLK_PS)));
  localparam int TURN_CYC  = ns_to_cyc(T_HZ_NS, CLK_PS);
  localparam int PWR_CYC   = ns_to_cyc(T_PWRUP_NS, CLK_PS);
  localparam int CNT_MAX   = imax(imax(PWR_CYC, PULSE_CYC), imax(imax(READ_CYC, TURN_CYC),
                                  imax(SETUP_CYC, HOLD_CYC)));
  localparam int TW        = $clog2(CNT_MAX + 1);

  ctl_state_t           state;
  logic                 tmr_load;
  logic [TW-1:0]        tmr_val;
  logic                 tmr_done;
  logic [LANES-1:0]     lat_mask;
  logic [DATA_W-1:0]    rd_merged;

  sram_ctl_timer #(
    .W       (TW),
    .RST_VAL (PWR_CYC - 1)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  sram_ctl_lanes #(
    .LANES  (LANES),
    .LANE_W (LANE_W)
  ) u_lanes (
    .mask   (lat_mask),
    .raw    (mem_dq_in),
    .merged (rd_merged)
  );

  // Phase length selection: each load starts a phase of (value+1) cycles.
  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (state)
      ST_IDLE: begin
        if (req_valid) begin
          tmr_load = 1'b1;
          tmr_val  = req_write ? TW'(SETUP_CYC - 1) : TW'(READ_CYC - 1);
        end
      end
      ST_WSETUP: begin
        if (tmr_done) begin
          tmr_load = 1'b1;
          tmr_val  = TW'(PULSE_CYC - 1);
        end
      end
      ST_WPULSE: begin
        if (tmr_done) begin
          tmr_load = 1'b1;
          tmr_val  = TW'(HOLD_CYC - 1);
        end
      end
      ST_READ: begin
        if (tmr_done) begin
          tmr_load = 1'b1;
          tmr_val  = TW'(TURN_CYC - 1);
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_PWRUP;
      req_ready  <= 1'b0;
      rd_valid   <= 1'b0;
      rd_data    <= '0;
      mem_addr   <= '0;
      mem_ce_n   <= 1'b1;
      mem_we_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_bsel_n <= '1;
      mem_dq_out <= '0;
      mem_dq_oe  <= 1'b0;
      lat_mask   <= '0;
    end else begin
      rd_valid <= 1'b0;
      case (state)
        ST_PWRUP: begin
          if (tmr_done) begin
            state     <= ST_IDLE;
            req_ready <= 1'b1;
          end
        end
        ST_IDLE: begin
          if (req_valid) begin
            req_ready  <= 1'b0;
            mem_addr   <= req_addr;
            mem_ce_n   <= 1'b0;
            mem_bsel_n <= ~req_bmask;
            lat_mask   <= req_bmask;
            if (req_write) begin
              mem_dq_out <= req_wdata;
              mem_dq_oe  <= 1'b1;
              state      <= ST_WSETUP;
            end else begin
              mem_oe_n   <= 1'b0;
              state      <= ST_READ;
            end
          end
        end
        ST_WSETUP: begin
          if (tmr_done) begin
            mem_we_n <= 1'b0;
            state    <= ST_WPULSE;
          end
        end
        ST_WPULSE: begin
          if (tmr_done) begin
            mem_we_n <= 1'b1;
            state    <= ST_WHOLD;
          end
        end
        ST_WHOLD: begin
          if (tmr_done) begin
            mem_ce_n   <= 1'b1;
            mem_bsel_n <= '1;
            mem_dq_oe  <= 1'b0;
            req_ready  <= 1'b1;
            state      <= ST_IDLE;
          end
        end
        ST_READ: begin
          if (tmr_done) begin
            rd_data    <= rd_merged;
            rd_valid   <= 1'b1;
            mem_ce_n   <= 1'b1;
            mem_oe_n   <= 1'b1;
            mem_bsel_n <= '1;
            state      <= ST_TURN;
          end
        end
        ST_TURN: begin
          if (tmr_done) begin
            req_ready <= 1'b1;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk #(
  parameter int ADDR_W   = 17,
  parameter int DATA_W   = 16,
  parameter int TURN_CYC = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rd_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic [DATA_W-1:0] mem_dq_out,
  input logic              mem_dq_oe
);

  // Cycles the output strobe has been high, saturating.
  logic [15:0] oe_high_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_high_cnt <= 16'hFFFF;
    end else if (!mem_oe_n) begin
      oe_high_cnt <= '0;
    end else if (oe_high_cnt != 16'hFFFF) begin
      oe_high_cnt <= oe_high_cnt + 16'd1;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe)); // R1

  AST_WRITE_OE_HIGH: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (mem_oe_n && !mem_ce_n && mem_dq_oe)); // R2

  AST_WE_ENDS_FIRST: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_ce_n) |-> $past(mem_we_n)); // R3

  AST_WRITE_HOLD: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (mem_dq_oe && !mem_ce_n && $stable(mem_dq_out) && $stable(mem_addr))); // R3

  AST_READ_STROBES: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> (mem_we_n && !mem_ce_n)); // R4

  AST_RDV_PULSE: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid); // R4

  AST_TURNAROUND: assert property (@(posedge clk) disable iff (rst)
    (!mem_dq_oe && mem_oe_n && (oe_high_cnt < 16'(TURN_CYC - 1))) |=> !mem_dq_oe); // R6

  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (rst)
    !(mem_dq_oe && !mem_oe_n)); // R7

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready); // R8

endmodule

bind sram_ctl sram_ctl_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .TURN_CYC (TURN_CYC)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .rd_valid   (rd_valid),
  .mem_addr   (mem_addr),
  .mem_ce_n   (mem_ce_n),
  .mem_we_n   (mem_we_n),
  .mem_oe_n   (mem_oe_n),
  .mem_dq_out (mem_dq_out),
  .mem_dq_oe  (mem_dq_oe)
);

// File: tb/test_sram_ctl.sv
`timescale 1ns/1ps
module test_sram_ctl;

  localparam int CLK_PS = 5000;
  localparam int AW = 17;
  localparam int DW = 16;

  function automatic int cyc(input int ns);
    int c;
    c = (ns * 1000 + CLK_PS - 1) / CLK_PS;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int E_PWE   = cyc(35);
  localparam int E_AW    = cyc(35);
  localparam int E_DS    = cyc(25);
  localparam int E_WC    = cyc(45);
  localparam int E_RD    = (cyc(45) > cyc(22)) ? cyc(45) : cyc(22);
  localparam int E_HZ    = cyc(18);
  localparam int E_PWR   = cyc(200000);
  localparam int E_WBUSY = (E_WC > E_PWE + 2) ? E_WC : E_PWE + 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [1:0] req_bmask = '0;
  logic req_ready, rd_valid;
  logic [DW-1:0] rd_data;
  logic [AW-1:0] mem_addr;
  logic mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [1:0] mem_bsel_n;
  logic [DW-1:0] mem_dq_out;
  logic [DW-1:0] mem_dq_in = 16'hDEAD;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  sram_ctl i_sram_ctl (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_bmask(req_bmask),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_bsel_n(mem_bsel_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- behavioural memory model ----------------
  logic [DW-1:0] model_mem [int];
  logic [DW-1:0] sb [int];
  int rd_cnt, we_cnt, ce_cnt, dq_cnt, hz_cnt;
  logic prev_we_n, prev_ce_n, prev_dq_oe;
  bit wr_open;

  always @(negedge clk) begin
    if (rst) begin
      rd_cnt = 0; we_cnt = 0; ce_cnt = 0; dq_cnt = 0; hz_cnt = 1000;
      prev_we_n = 1'b1; prev_ce_n = 1'b1; prev_dq_oe = 1'b0; wr_open = 1'b0;
      mem_dq_in <= 16'hDEAD;
    end else begin
      if (mem_dq_oe && !mem_oe_n)
        check(1'b0, "R7 bus contention", {30'd0, mem_dq_oe, mem_oe_n}, 32'h2);
      if (!prev_we_n && mem_we_n) begin
        logic [DW-1:0] w;
        check(we_cnt >= E_PWE, "R2 write pulse cycles", we_cnt, E_PWE);
        check(ce_cnt >= E_AW, "R3 address setup cycles", ce_cnt, E_AW);
        check(dq_cnt >= E_DS, "R3 data setup cycles", dq_cnt, E_DS);
        check(!mem_ce_n && mem_dq_oe, "R3 select and data held at write end",
              {30'd0, mem_ce_n, mem_dq_oe}, 32'h1);
        w = model_mem.exists(int'(mem_addr)) ? model_mem[int'(mem_addr)] : '0;
        if (!mem_bsel_n[0]) w[7:0]  = mem_dq_out[7:0];
        if (!mem_bsel_n[1]) w[15:8] = mem_dq_out[15:8];
        model_mem[int'(mem_addr)] = w;
        wr_open = 1'b1;
      end
      if (!prev_ce_n && mem_ce_n && wr_open) begin
        check(ce_cnt >= E_WC, "R3 write cycle time", ce_cnt, E_WC);
        wr_open = 1'b0;
      end
      if (!prev_dq_oe && mem_dq_oe)
        check(hz_cnt >= E_HZ, "R6 bus turnaround", hz_cnt, E_HZ);
      we_cnt = !mem_we_n ? we_cnt + 1 : 0;
      ce_cnt = !mem_ce_n ? ce_cnt + 1 : 0;
      dq_cnt = mem_dq_oe ? dq_cnt + 1 : 0;
      hz_cnt = mem_oe_n ? ((hz_cnt < 1000) ? hz_cnt + 1 : hz_cnt) : 0;
      rd_cnt = (!mem_ce_n && !mem_oe_n && mem_we_n) ? rd_cnt + 1 : 0;
      prev_we_n = mem_we_n; prev_ce_n = mem_ce_n; prev_dq_oe = mem_dq_oe;
      if (rd_cnt >= E_RD) begin
        logic [DW-1:0] r;
        r = model_mem.exists(int'(mem_addr)) ? model_mem[int'(mem_addr)] : '0;
        mem_dq_in <= {mem_bsel_n[1] ? 8'hA5 : r[15:8], mem_bsel_n[0] ? 8'h5A : r[7:0]};
      end else begin
        mem_dq_in <= 16'hDEAD;
      end
    end
  end

  // ---------------- host tasks (entered at a negedge) ----------------
  function automatic logic [DW-1:0] sb_get(input logic [AW-1:0] a);
    return sb.exists(int'(a)) ? sb[int'(a)] : '0;
  endfunction

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [1:0] m);
    int k;
    logic [DW-1:0] w;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_bmask = m;
    @(negedge clk);
    req_valid = 1'b0;
    k = 0;
    check(!req_ready, "R8 ready low after write accept", {31'd0, req_ready}, 32'h0);
    while (!req_ready && k < 100) begin @(negedge clk); k++; end
    check(k == E_WBUSY, "R9 write busy cycles", k, E_WBUSY);
    w = sb_get(a);
    if (m[0]) w[7:0]  = d[7:0];
    if (m[1]) w[15:8] = d[15:8];
    sb[int'(a)] = w;
  endtask

  task automatic do_read(input logic [AW-1:0] a, input logic [1:0] m, input string tag);
    int k;
    logic [DW-1:0] exp;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_bmask = m;
    @(negedge clk);
    req_valid = 1'b0;
    k = 0;
    while (!rd_valid && k < 100) begin @(negedge clk); k++; end
    check(k == E_RD, "R9 read latency", k, E_RD);
    exp = sb_get(a) & {{8{m[1]}}, {8{m[0]}}};
    check(rd_data === exp, tag, rd_data, exp);
    @(negedge clk); k++;
    check(!rd_valid, "R4 rd_valid single pulse", {31'd0, rd_valid}, 32'h0);
    while (!req_ready && k < 100) begin @(negedge clk); k++; end
    check(k == E_RD + E_HZ, "R8 R9 ready after read and gap", k, E_RD + E_HZ);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    int k;
    repeat (4) @(negedge clk);
    check(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && !req_ready,
          "R1 reset state", {27'd0, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, req_ready}, 32'h1C);
    rst = 1'b0;
    k = 0;
    while (!req_ready && k < E_PWR + 10) begin @(negedge clk); k++; end
    check(k == E_PWR, "R1 R9 power-up wait", k, E_PWR);
    check(mem_ce_n && mem_we_n && mem_oe_n, "R1 idle strobes", {29'd0, mem_ce_n, mem_we_n, mem_oe_n}, 32'h7);

    // Near-exhaustive sweep: every write mask, then every read mask.
    for (int i = 0; i < 8; i++) begin
      logic [AW-1:0] a;
      a = (i == 7) ? 17'h1FFFF : AW'(i * 9363);
      for (int m = 0; m < 4; m++) begin
        do_write(a, DW'(int'(a) * 40503 + m * 4369 + 7), 2'(m));
        for (int r = 0; r < 4; r++)
          do_read(a, 2'(r), (m == 0) ? "R5 mask 00 write leaves word" : "R5 R4 masked readback");
      end
    end

    // Back-to-back read then write (turnaround) and write then read.
    do_read(17'h00123, 2'b11, "R4 read before write");
    do_write(17'h00123, 16'hC3E1, 2'b11);
    do_read(17'h00123, 2'b11, "R3 data held into write end");

    // R8: a request held valid while busy with other fields is ignored.
    do_write(17'h0AAAA, 16'h1111, 2'b11);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 17'h05555; req_wdata = 16'h2222; req_bmask = 2'b11;
    @(negedge clk);
    req_addr = 17'h0AAAA; req_wdata = 16'hBEEF;
    for (int j = 0; j < E_WBUSY - 1; j++) @(negedge clk);
    req_valid = 1'b0;
    sb[int'(17'h05555)] = 16'h2222;
    do_read(17'h0AAAA, 2'b11, "R8 busy request ignored");
    do_read(17'h05555, 2'b11, "R8 accepted write landed");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule